// File: doc/BRIEF.md
# Timed-Unlock Sleep Control Register

This block is an 8-bit power-management control register that a CPU writes and reads. Most of its fields are plain storage: a sleep-enable flag, a two-bit sleep-mode selector, a pull-up disable flag and a two-bit interrupt-sense selector. These drive the rest of the chip. One field asks for the brown-out detector to be switched off while the chip sleeps. Software can set it only through a timed two-write unlock, and it lives for a short fixed time only.

The first write of the unlock sets the detector-sleep bit (bit 7) and the unlock-enable bit (bit 2) together. That write opens a window of four clocks. If a write with bit 7 at 1 and bit 2 at 0 lands inside that window, the detector-sleep bit becomes 1. It reads back as 1 for three cycles and then clears itself. The qualifier is live for the three cycles that follow.

The core raises a sleep strobe to execute its sleep instruction. The block samples that strobe. If sleep-enable is set, it answers one cycle later with a one-cycle sleep request. That request carries the mode bits and the detector-off qualifier as they were at the sampling edge.

Top module: `sleep_ctrl_reg`

## Requirements
- R1: After reset, rd_data reads 0x00, and sleep_req, bod_off, pull_up_dis and int_sense are all 0.
- R2: A write stores bit 6 (pull-up disable), bit 5 (sleep enable), bits 4:3 (sleep mode, bit 4 high) and bits 1:0 (interrupt sense). These read back at the same positions from the cycle after the write, and drive pull_up_dis and int_sense.
- R3: A write with bit 7 = 1 and bit 2 = 1 is an opening write. From the next cycle, bit 2 reads 1 while the window is open. Bit 2 reads 0 again after four cycles with no write.
- R4: A write with bit 7 = 1 and bit 2 = 0 is a confirming write. If it lands within four cycles after an opening write, bit 7 reads 1 for exactly three cycles starting the cycle after the write, then reads 0. Bit 2 reads 0 from that cycle on.
- R5: A confirming write that arrives late has no effect on bit 7. Any write with bit 7 = 0 while the window is open closes the window, and a later confirming write then has no effect on bit 7. Outside a window, a write with bit 7 = 1 and bit 2 = 0 leaves bit 7 at 0.
- R6: An opening write while the window is open restarts the four-cycle window.
- R7: The detector-off qualifier is live during the three cycles that follow the three cycles when bit 7 reads 1. bod_off is 1 with a sleep request only when the strobe was sampled during that live span.
- R8: A strobe sampled while bit 5 is 1 gives sleep_req high for one cycle, in the cycle after the sampling edge. sleep_mode then holds bits 4:3 as they were at the sampling edge. A strobe sampled while bit 5 is 0 gives no request.
- R9: With HAS_BOD_SLEEP = 0, bits 7 and 2 always read 0 and bod_off is never 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| sleep_strobe | input | 1 | Sleep instruction executed |
| sleep_req | output | 1 | One-cycle sleep request |
| sleep_mode | output | 2 | Mode captured with the request |
| bod_off | output | 1 | Detector off for this sleep period |
| pull_up_dis | output | 1 | Global pull-up disable |
| int_sense | output | 2 | Interrupt sense selection |

## Verification
Faults in the unlock counter or the detector-sleep phase counter show up on bit 7 or bit 2 of rd_data within one to seven cycles of an unlock attempt. The bench reads the register back on each cycle around each window edge. A fault in the live span shows as a wrong bod_off on the request that follows the strobe by one cycle. The bench places its strobes on the first and last live cycles and on the cycle just after the span. A wrong sampling edge in the strobe path shows as a mode or qualifier taken from the wrong cycle.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_BODSLP = 7;
  localparam int unsigned B_PUDIS  = 6;
  localparam int unsigned B_SLPEN  = 5;
  localparam int unsigned B_MODEH  = 4;
  localparam int unsigned B_MODEL  = 3;
  localparam int unsigned B_UNLOCK = 2;
  localparam int unsigned B_SENSEH = 1;
  localparam int unsigned B_SENSEL = 0;

  typedef struct packed {
    logic       pull_up_dis;
    logic       sleep_en;
    logic [1:0] mode;
    logic [1:0] sense;
  } plain_fields_t;

  function automatic logic is_opening(input logic [REG_W-1:0] d);
    return d[B_BODSLP] & d[B_UNLOCK];
  endfunction

  function automatic logic is_confirming(input logic [REG_W-1:0] d);
    return d[B_BODSLP] & ~d[B_UNLOCK];
  endfunction

  function automatic plain_fields_t unpack_plain(input logic [REG_W-1:0] d);
    plain_fields_t f;
    f.pull_up_dis = d[B_PUDIS];
    f.sleep_en    = d[B_SLPEN];
    f.mode        = d[B_MODEH:B_MODEL];
    f.sense       = d[B_SENSEH:B_SENSEL];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] pack_read(input plain_fields_t f,
                                                 input logic bodslp,
                                                 input logic unlock);
    logic [REG_W-1:0] r;
    r                   = '0;
    r[B_BODSLP]         = bodslp;
    r[B_PUDIS]          = f.pull_up_dis;
    r[B_SLPEN]          = f.sleep_en;
    r[B_MODEH:B_MODEL]  = f.mode;
    r[B_UNLOCK]         = unlock;
    r[B_SENSEH:B_SENSEL]= f.sense;
    return r;
  endfunction

endpackage

// File: rtl/sleep_unlock_window.sv
module sleep_unlock_window
  import sleep_ctrl_pkg::*;
#(
  parameter int unsigned WINDOW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             window_open,
  output logic             accept_ev
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LOAD = CW'(WINDOW);

  logic [CW-1:0] cnt_q;
  logic          open_ev;

  assign window_open = (cnt_q != '0);
  assign open_ev     = wr_en & is_opening(wr_data);
  assign accept_ev   = wr_en & window_open & is_confirming(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (open_ev)     cnt_q <= LOAD;
    else if (wr_en)       cnt_q <= '0;
    else if (window_open) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/bod_sleep_timer.sv
module bod_sleep_timer #(
  parameter int unsigned ARM_CYC  = 3,
  parameter int unsigned LIVE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic bit_visible,
  output logic live
);
  localparam int unsigned SPAN = ARM_CYC + LIVE_CYC;
  localparam int unsigned PW   = $clog2(SPAN + 1);
  localparam logic [PW-1:0] LAST = PW'(SPAN);
  localparam logic [PW-1:0] ARM  = PW'(ARM_CYC);

  logic [PW-1:0] phase_q;

  assign bit_visible = (phase_q != '0) && (phase_q <= ARM);
  assign live        = (phase_q > ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (start)           phase_q <= PW'(1);
    else if (phase_q == LAST) phase_q <= '0;
    else if (phase_q != '0)   phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/sleep_strobe_gate.sv
module sleep_strobe_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       sleep_en,
  input  logic [1:0] mode,
  input  logic       bod_live,
  output logic       req,
  output logic [1:0] req_mode,
  output logic       req_bod_off
);
  logic take;
  assign take = strobe & sleep_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req         <= 1'b0;
      req_mode    <= '0;
      req_bod_off <= 1'b0;
    end else begin
      req <= take;
      if (take) begin
        req_mode    <= mode;
        req_bod_off <= bod_live;
      end else begin
        req_bod_off <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sleep_ctrl_reg.sv
module sleep_ctrl_reg
  import sleep_ctrl_pkg::*;
#(
  parameter bit          HAS_BOD_SLEEP = 1'b1,
  parameter int unsigned WINDOW        = 4,
  parameter int unsigned ARM_CYC       = 3,
  parameter int unsigned LIVE_CYC      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sleep_strobe,
  output logic       sleep_req,
  output logic [1:0] sleep_mode,
  output logic       bod_off,
  output logic       pull_up_dis,
  output logic [1:0] int_sense
);
  plain_fields_t fields_q;
  logic          window_open;
  logic          accept_ev;
  logic          bods_visible;
  logic          bods_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fields_q <= '0;
    else if (wr_en) fields_q <= unpack_plain(wr_data);
  end

  generate
    if (HAS_BOD_SLEEP) begin : g_bod
      sleep_unlock_window #(.WINDOW(WINDOW)) u_win (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .window_open(window_open), .accept_ev(accept_ev)
      );
      bod_sleep_timer #(.ARM_CYC(ARM_CYC), .LIVE_CYC(LIVE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(accept_ev),
        .bit_visible(bods_visible), .live(bods_active)
      );
    end else begin : g_nobod
      assign window_open  = 1'b0;
      assign accept_ev    = 1'b0;
      assign bods_visible = 1'b0;
      assign bods_active  = 1'b0;
    end
  endgenerate

  sleep_strobe_gate u_gate (
    .clk(clk), .rst_n(rst_n), .strobe(sleep_strobe),
    .sleep_en(fields_q.sleep_en), .mode(fields_q.mode),
    .bod_live(bods_active), .req(sleep_req), .req_mode(sleep_mode),
    .req_bod_off(bod_off)
  );

  assign rd_data     = pack_read(fields_q, bods_visible, window_open);
  assign pull_up_dis = fields_q.pull_up_dis;
  assign int_sense   = fields_q.sense;
endmodule

// File: rtl/sleep_ctrl_reg_chk.sv
module sleep_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       sleep_strobe,
  input logic [7:0] rd_data,
  input logic       window_open,
  input logic       accept_ev,
  input logic       bods_active,
  input logic       sleep_req,
  input logic       bod_off
);
  // R4: bit 7 only rises after an accepted confirming write
  a_r4_bods_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[7]) |-> $past(accept_ev));

  // R5: a write outside the window never raises bit 7
  a_r5_no_set_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !window_open && !rd_data[7]) |=> !rd_data[7]);

  // R7: the live span starts only right after bit 7 was showing
  a_r7_live_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bods_active) |-> $past(rd_data[7]));

  // R7: the qualifier comes only with a request
  a_r7_qual_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    bod_off |-> sleep_req);

  // R8: a request needs a strobe while sleep enable was set
  a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past(sleep_strobe && rd_data[5]));
endmodule

bind sleep_ctrl_reg sleep_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sleep_strobe(sleep_strobe),
  .rd_data(rd_data), .window_open(window_open), .accept_ev(accept_ev),
  .bods_active(bods_active), .sleep_req(sleep_req), .bod_off(bod_off)
);

// File: tb/sleep_ctrl_reg_test.sv
module sleep_ctrl_reg_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       sleep_strobe;
  logic [7:0] rd_data, rd_nb;
  logic       sleep_req, req_nb;
  logic [1:0] sleep_mode, mode_nb;
  logic       bod_off, bod_nb;
  logic       pull_up_dis, pud_nb;
  logic [1:0] int_sense, sense_nb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [2:0] exp_q[$];
  logic [7:0] shadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep_strobe(sleep_strobe), .sleep_req(sleep_req),
    .sleep_mode(sleep_mode), .bod_off(bod_off), .pull_up_dis(pull_up_dis),
    .int_sense(int_sense)
  );

  sleep_ctrl_reg #(.HAS_BOD_SLEEP(1'b0)) uut_nb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_nb), .sleep_strobe(sleep_strobe), .sleep_req(req_nb),
    .sleep_mode(mode_nb), .bod_off(bod_nb), .pull_up_dis(pud_nb),
    .int_sense(sense_nb)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    shadow = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes the expected request, bench-side model of sleep enable
  task automatic strobe(input logic exp_bod);
    if (shadow[5]) exp_q.push_back({shadow[4:3], exp_bod});
    sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0;
  endtask

  // monitor: pops and compares each request
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sleep_req) begin
        if (exp_q.size() == 0) check("R8 unexpected request", 8'd1, 8'd0);
        else check("R7/R8 request mode,qualifier", {5'd0, sleep_mode, bod_off},
                   {5'd0, exp_q.pop_front()});
      end
      if (bod_nb) check("R9 qualifier without feature", 8'd1, 8'd0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sleep_strobe = 1'b0; shadow = '0;
    idle(3);
    check("R1 reset read", rd_data, 8'h00);
    check("R1 reset outputs", {4'd0, sleep_req, bod_off, pull_up_dis, int_sense[0] | int_sense[1]}, 8'h00);
    rst_n = 1'b1;
    idle(1);
    check("R1 read after release", rd_data, 8'h00);

    wr(8'h5B);
    check("R2 plain readback", rd_data, 8'h5B);
    check("R2 field outputs", {5'd0, pull_up_dis, int_sense}, 8'h07);

    wr(8'hA0);
    check("R5 confirm outside window", rd_data, 8'h20);

    // opening, confirm on the fourth cycle
    wr(8'hA4);
    check("R3 window open", rd_data, 8'h24);
    check("R9 window absent", rd_nb, 8'h20);
    idle(3);
    check("R3 window still open", rd_data, 8'h24);
    wr(8'hA0);
    check("R4 bit set", rd_data, 8'hA0);
    check("R9 bit absent", rd_nb, 8'h20);
    idle(2);
    check("R4 bit third cycle", rd_data, 8'hA0);
    idle(1);
    check("R4 bit self-clear", rd_data, 8'h20);
    strobe(1'b1);           // first live cycle  R7
    idle(1);
    strobe(1'b1);           // last live cycle   R7
    strobe(1'b0);           // span over         R7

    // timeout
    wr(8'hA4);
    idle(4);
    check("R3 window expired", rd_data, 8'h20);
    wr(8'hA0);
    check("R5 late confirm", rd_data, 8'h20);

    // abandoned by another value
    wr(8'hA4);
    wr(8'h24);
    check("R5 abandon closes window", rd_data, 8'h20);
    wr(8'hA0);
    check("R5 confirm after abandon", rd_data, 8'h20);

    // restart
    wr(8'hA4);
    idle(3);
    wr(8'hA4);
    check("R6 reopened", rd_data, 8'h24);
    idle(3);
    wr(8'hA0);
    check("R6 confirm in restarted window", rd_data, 8'hA0);
    idle(6);

    // sleep enable gating and mode capture
    wr(8'h18);
    strobe(1'b0);
    check("R8 no request when disabled", {7'd0, sleep_req}, 8'h00);
    wr(8'h30);
    strobe(1'b0);
    check("R8 pulse high", {7'd0, sleep_req}, 8'h01);
    idle(1);
    check("R8 pulse one cycle", {7'd0, sleep_req}, 8'h00);
    wr(8'h28);
    strobe(1'b0);

    idle(2);
    check("R8 all requests seen", 8'(exp_q.size()), 8'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule